// File: doc/BRIEF.md
# Pin Interrupt GPIO Port

A 32-pin general-purpose I/O port with a register bus and per-pin interrupt detection. Software drives the pins through an output data register and an output enable register, and reads back synchronized pin levels through an input register. Any pin can be routed into interrupt detection. Each routed pin has its own trigger type: rising edge, falling edge, high level or low level. A detected event sets a sticky status bit. The port raises one combined interrupt line whenever an enabled status bit is set.

Every register occupies a 16-byte block. Inside the block there are three addresses: one loads the register, one ORs a mask into it, and one clears the masked bits. Software can therefore change single bits without a read-modify-write. Status bits can only be cleared through their clear address. In level mode a status bit is set again on every cycle that the pin stays at its active level.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, and pin_out, pin_oe and irq_out are low.
- R2: Address bits [6:4] select the register in this order: 0 output data, 1 input, 2 output enable, 3 interrupt select, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Address bits [3:0] select the access: 0x0 load, 0x4 set, 0x8 clear. A read of any of the three returns the register value on bus_rdata in the cycle after the read strobe. A read at offset 0xC returns zero, and a write there has no effect.
- R3: For the output data, output enable, interrupt select, interrupt enable, level and polarity registers, a write at 0x0 loads bus_wdata. A write at 0x4 sets the bits that are one in bus_wdata. A write at 0x8 clears those bits. All other bits keep their value.
- R4: pin_out equals the output data register and pin_oe equals the output enable register.
- R5: The input register returns pin_in after a two-flop synchronizer. Writes to the input register have no effect.
- R6: Each pin's trigger is set by its level bit and its polarity bit. Level 0 with polarity 1 detects a rising edge, and level 0 with polarity 0 a falling edge. An edge is a change of the synchronized value to the polarity value. Level 1 with polarity 1 detects a high level, and level 1 with polarity 0 a low level.
- R7: In level mode the status bit is set on every cycle that the synchronized pin is at its active level. A clear issued while that level persists leaves the bit set.
- R8: Status bits are sticky. Only a write at the status clear address (0x78) clears them. Writes at 0x70 and 0x74 have no effect. A detection in the same cycle as a clear wins.
- R9: A pin whose interrupt select bit is zero never sets its status bit.
- R10: A status bit sets whether or not its enable bit is set. irq_out is high exactly when some pin has both its status bit and its enable bit set.
- R11: A pin change applied before clock edge k makes irq_out high after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data / mask |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable to the pads |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A pin change reaches the status register three edges after it is driven: two synchronizer stages and then the status flop. irq_out follows status without a further register. Read data appears one edge after the read strobe. Register writes act on the edge of the strobe, so pin_out and pin_oe change at that edge. The bench drives inputs on falling edges and samples on falling edges. It checks the irq_out latency edge by edge. Everything else waits at least four cycles after a pin change before it reads the status register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_REGS  = 8;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int OFF_W     = 4;
    localparam int ADDR_W    = REG_IDX_W + OFF_W;

    typedef enum logic [REG_IDX_W-1:0] {
        RI_DOUT = 3'd0,
        RI_DIN  = 3'd1,
        RI_OE   = 3'd2,
        RI_SEL  = 3'd3,
        RI_IEN  = 3'd4,
        RI_LVL  = 3'd5,
        RI_POL  = 3'd6,
        RI_STAT = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        AL_BASE = 2'd0,
        AL_SET  = 2'd1,
        AL_CLR  = 2'd2,
        AL_NONE = 2'd3
    } alias_e;

    typedef struct packed {
        logic [NUM_REGS-1:0] load;
        logic [NUM_REGS-1:0] set;
        logic [NUM_REGS-1:0] clr;
    } wr_strobe_t;

    function automatic alias_e decode_alias(input logic [OFF_W-1:0] off);
        case (off)
            4'h0:    return AL_BASE;
            4'h4:    return AL_SET;
            4'h8:    return AL_CLR;
            default: return AL_NONE;
        endcase
    endfunction

    // lvl: 0 edge, 1 level; pol: 0 falling/low, 1 rising/high
    function automatic logic trig_hit(input logic lvl, input logic pol,
                                      input logic cur, input logic prev);
        logic at_active;
        at_active = (cur == pol);
        if (lvl)
            return at_active;
        return at_active && (prev != pol);
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_irq_pkg::*;
(
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output wr_strobe_t           strobe,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic                 alias_ok
);
    alias_e acc;

    always_comb begin
        acc      = decode_alias(bus_addr[OFF_W-1:0]);
        reg_idx  = bus_addr[ADDR_W-1:OFF_W];
        alias_ok = (acc != AL_NONE);
        strobe   = '0;
        if (bus_wr) begin
            case (acc)
                AL_BASE: strobe.load[reg_idx] = 1'b1;
                AL_SET:  strobe.set[reg_idx]  = 1'b1;
                AL_CLR:  strobe.clr[reg_idx]  = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= pin_in;
            cur    <= meta_q;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg #(
    parameter int WIDTH     = 32,
    parameter bit SW_LOAD   = 1'b1,
    parameter bit SW_SET    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_load,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] hw_set,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        nxt = q;
        if (SW_LOAD && wr_load) nxt = wdata;
        if (SW_SET && wr_set)   nxt = nxt | wdata;
        if (wr_clr)             nxt = nxt & ~wdata;
        nxt = nxt | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R3
    generate
        if (SW_SET) begin : g_set_chk
            r3_set_alias_chk: assert property (@(posedge clk) disable iff (rst)
                wr_set |=> ((q & $past(q | wdata)) == $past(q | wdata)));
        end
    endgenerate
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sel,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] pol,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    output logic [WIDTH-1:0] hit
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign hit[i] = sel[i] & trig_hit(lvl[i], pol[i], cur[i], prev[i]);
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_out
);
    wr_strobe_t           strobe;
    logic [REG_IDX_W-1:0] reg_idx;
    logic                 alias_ok;
    logic [NPINS-1:0]     din_s;
    logic [NPINS-1:0]     din_p;
    logic [NPINS-1:0]     hit;
    logic [NPINS-1:0]     regv [NUM_REGS];

    gpio_bus_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .strobe   (strobe),
        .reg_idx  (reg_idx),
        .alias_ok (alias_ok)
    );

    gpio_in_sync #(.WIDTH(NPINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .cur    (din_s),
        .prev   (din_p)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == int'(RI_DIN)) begin : g_in
            assign regv[g] = din_s;
        end else begin : g_rw
            localparam bit IS_STAT = (g == int'(RI_STAT));
            gpio_ctl_reg #(
                .WIDTH   (NPINS),
                .SW_LOAD (!IS_STAT),
                .SW_SET  (!IS_STAT)
            ) u_reg (
                .clk     (clk),
                .rst     (rst),
                .wr_load (strobe.load[g]),
                .wr_set  (strobe.set[g]),
                .wr_clr  (strobe.clr[g]),
                .wdata   (bus_wdata),
                .hw_set  (IS_STAT ? hit : '0),
                .q       (regv[g])
            );
        end
    end

    gpio_trig_detect #(.WIDTH(NPINS)) u_det (
        .sel  (regv[RI_SEL]),
        .lvl  (regv[RI_LVL]),
        .pol  (regv[RI_POL]),
        .cur  (din_s),
        .prev (din_p),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= alias_ok ? regv[reg_idx] : '0;
    end

    assign pin_out = regv[RI_DOUT];
    assign pin_oe  = regv[RI_OE];
    assign irq_out = |(regv[RI_STAT] & regv[RI_IEN]);

    logic [NPINS-1:0] stat_clr_mask;
    logic [NPINS-1:0] lvl_hold;
    assign stat_clr_mask = strobe.clr[RI_STAT] ? bus_wdata : '0;
    assign lvl_hold      = regv[RI_SEL] & regv[RI_LVL] & ~(din_s ^ regv[RI_POL]);

    // R8
    r8_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~regv[RI_STAT] & $past(regv[RI_STAT]) & ~$past(stat_clr_mask)) == '0));

    // R9
    r9_sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((regv[RI_STAT] & ~$past(regv[RI_STAT]) & ~$past(regv[RI_SEL])) == '0));

    // R7
    r7_level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(lvl_hold) & ~regv[RI_STAT]) == '0));

    // R10
    r10_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (regv[RI_STAT] != '0 && regv[RI_IEN] != '0));
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpio_irq_port dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [6:0] ad(input int r, input int off);
        return 7'((r << 4) | off);
    endfunction

    // expected register value after a software access (R3)
    function automatic logic [N-1:0] apply(input logic [N-1:0] old, input int off, input logic [N-1:0] d);
        case (off)
            0:       return d;
            4:       return old | d;
            8:       return old & ~d;
            default: return old;
        endcase
    endfunction

    logic [N-1:0] model [8];
    logic [N-1:0] v;

    // one pin through one trigger mode (R6, R7, R8, R10)
    task automatic trig_case(input int p, input bit lvl, input bit pol);
        logic [N-1:0] m;
        m = 32'h1 << p;
        pin_in[p] = ~pol;
        idle(4);
        wr(ad(5, lvl ? 4 : 8), m);
        wr(ad(6, pol ? 4 : 8), m);
        wr(ad(3, 4), m);
        wr(ad(4, 4), m);
        wr(ad(7, 8), '1);
        rd(ad(7, 0), v);
        check("R6 idle status", v, '0);
        @(negedge clk); pin_in[p] = pol;
        idle(4);
        rd(ad(7, 0), v);
        check("R6 active status", v, m);
        check("R10 irq_out", {31'b0, irq_out}, 32'h1);
        wr(ad(7, 8), m);
        rd(ad(7, 0), v);
        check(lvl ? "R7 clear while active" : "R8 edge cleared", v, lvl ? m : '0);
        @(negedge clk); pin_in[p] = ~pol;
        idle(4);
        wr(ad(7, 8), m);
        rd(ad(7, 4), v);
        check("R8 cleared after inactive", v, '0);
        check("R10 irq low", {31'b0, irq_out}, 32'h0);
        wr(ad(3, 8), m);
        wr(ad(4, 8), m);
    endtask

    initial begin
        logic [N-1:0] d;
        int r, off;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq_out", {31'b0, irq_out}, '0);
        for (int i = 0; i < 8; i++) begin
            rd(ad(i, 0), v);
            check("R1 reg read", v, '0);
            model[i] = '0;
        end

        // R3 R4 R2 random register traffic
        for (int k = 0; k < 300; k++) begin
            case ($urandom % 6)
                0: r = 0; 1: r = 2; 2: r = 3; 3: r = 4; 4: r = 5; default: r = 6;
            endcase
            off = 4 * ($urandom % 3);
            d = $urandom;
            wr(ad(r, off), d);
            model[r] = apply(model[r], off, d);
            rd(ad(r, 4 * ($urandom % 3)), v);
            check("R3 alias readback", v, model[r]);
            check("R4 pin_out", pin_out, model[0]);
            check("R4 pin_oe", pin_oe, model[2]);
        end

        // R2 offset 0xC ignored and reads zero
        wr(ad(0, 12), 32'hffff_ffff);
        check("R2 offset C write ignored", pin_out, model[0]);
        rd(ad(0, 12), v);
        check("R2 offset C read", v, '0);

        for (int i = 2; i < 7; i++) wr(ad(i, 0), '0);
        wr(ad(0, 0), '0);
        idle(2);
        wr(ad(7, 8), '1);
        rd(ad(7, 0), v);
        check("R8 status cleared", v, '0);

        // R5 input sync and write-ignore
        pin_in = 32'hA5C3_0F96;
        idle(3);
        rd(ad(1, 0), v);
        check("R5 din", v, 32'hA5C3_0F96);
        wr(ad(1, 0), 32'h0);
        wr(ad(1, 8), 32'hffff_ffff);
        rd(ad(1, 8), v);
        check("R5 din write ignored", v, 32'hA5C3_0F96);
        pin_in = '0;
        idle(4);

        // R11 latency, rising edge on pin 5
        wr(ad(6, 4), 32'h20);
        wr(ad(3, 4), 32'h20);
        wr(ad(4, 4), 32'h20);
        @(negedge clk); pin_in[5] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R11 irq not before k+2", {31'b0, irq_out}, 32'h0);
        @(posedge clk); #1;
        check("R11 irq after k+2", {31'b0, irq_out}, 32'h1);

        // R8 load and set writes to status ignored
        wr(ad(7, 0), '0);
        wr(ad(7, 4), 32'h0000_0f00);
        rd(ad(7, 0), v);
        check("R8 status writes ignored", v, 32'h20);

        // R10 status without enable
        wr(ad(4, 8), 32'h20);
        idle(1);
        check("R10 irq masked", {31'b0, irq_out}, 32'h0);
        rd(ad(7, 0), v);
        check("R10 status kept", v, 32'h20);
        wr(ad(7, 8), 32'h20);
        wr(ad(3, 8), 32'h20);
        wr(ad(6, 8), 32'h20);
        pin_in[5] = 1'b0;
        idle(4);

        // R9 unselected pin: high level mode, enabled, not selected
        wr(ad(5, 4), 32'h400);
        wr(ad(6, 4), 32'h400);
        wr(ad(4, 4), 32'h400);
        @(negedge clk); pin_in[10] = 1'b1;
        idle(5);
        rd(ad(7, 0), v);
        check("R9 unselected status", v, '0);
        check("R9 unselected irq", {31'b0, irq_out}, 32'h0);
        pin_in[10] = 1'b0;
        wr(ad(5, 8), 32'h400);
        wr(ad(6, 8), 32'h400);
        wr(ad(4, 8), 32'h400);
        idle(4);

        // R6 R7 directed trigger modes
        trig_case(3, 1'b0, 1'b1);
        trig_case(9, 1'b0, 1'b0);
        trig_case(12, 1'b1, 1'b1);
        trig_case(20, 1'b1, 1'b0);
        trig_case(31, 1'b0, 1'b1);
        trig_case(0, 1'b1, 1'b0);

        // R6 random trigger modes
        for (int k = 0; k < 30; k++) begin
            int p;
            bit l, q;
            p = $urandom % N;
            l = 1'($urandom);
            q = 1'($urandom);
            trig_case(p, l, q);
            pin_in[p] = 1'b0;
            idle(4);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule